// File: doc/BRIEF.md
# Configurable Pin Cell

This block is the per-pin input/output cell of a programmable logic fabric. Toward the core it returns one captured input bit and takes one output bit plus an output enable produced by a logic block. Toward the pad it produces a driven value and a driver enable for an external tri-state buffer, and it reads the pad level. A small configuration word chooses how the input is captured (straight through, registered on a rising edge of an I/O clock line, or held by a level-sensitive latch), whether the driven value is inverted, which I/O clock line is used, and whether the pin acts as input only, output only or bidirectional.

Everything runs on one system clock `clk`. The I/O clock lines are sampled on that clock. A two-state line tracker, with states LINE_LOW and LINE_HIGH, follows the selected line. It moves LINE_LOW to LINE_HIGH when the sampled line is 1 and LINE_HIGH to LINE_LOW when it is 0. Its self-loops are LINE_LOW to LINE_LOW and LINE_HIGH to LINE_HIGH. The LINE_LOW to LINE_HIGH transition is the capture event of the registered mode. The configuration is loaded from the `cfg_*` inputs only on a clock edge where `cfg_load` is high. The active-low `rst_n` clears the configuration, the tracker and the stored input bit at once.

Top module: `pin_cell`

## Requirements
- R1: While `rst_n` is low and right after it rises, the configuration is capture mode combinatorial, direction input, no inversion and line 0, `pad_oe` is 0 and `core_i` follows `pad_i`.
- R2: The `cfg_*` inputs take effect only from the clock edge at which `cfg_load` is 1, and after that edge. At any other edge they have no effect on the outputs.
- R3: With capture mode 00 (combinatorial) or 11 (also combinatorial), `core_i` equals the input source in the same cycle.
- R4: With capture mode 01 (registered), the stored bit takes the input source at a clock edge where the selected line is 1 and was 0 at the previous edge. At every other edge it holds. `core_i` shows the stored bit.
- R5: With capture mode 10 (latched), `core_i` equals the input source while the selected line is 1. While the line is 0, `core_i` holds the source value sampled at the last clock edge at which the line was 1.
- R6: `cfg_clk_sel` = 0 selects `io_clk[0]` and `cfg_clk_sel` = 1 selects `io_clk[1]`. The unselected line has no effect.
- R7: `pad_o` equals `core_o` when `cfg_invert` is 0 and equals its complement when `cfg_invert` is 1.
- R8: With direction 00 (input) or 11 (also input), `pad_oe` is 0 whatever `core_oe` is, and the input source is `pad_i`.
- R9: With direction 01 (output), `pad_oe` is 1 and the input source is the driven value `pad_o`, not `pad_i`.
- R10: With direction 10 (bidirectional), `pad_oe` equals `core_oe` and the input source is `pad_i`.
- R11: Driving `rst_n` low clears the stored input bit and the configuration at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low global reset, asynchronous |
| io_clk | input | NCLK | I/O clock lines, sampled on `clk` |
| cfg_load | input | 1 | Load strobe for the configuration |
| cfg_cap_mode | input | 2 | 00 comb, 01 registered, 10 latched, 11 comb |
| cfg_dir | input | 2 | 00 input, 01 output, 10 bidirectional, 11 input |
| cfg_invert | input | 1 | Invert the driven value |
| cfg_clk_sel | input | SEL_W | Index of the I/O clock line |
| core_o | input | 1 | Value to drive from the core |
| core_oe | input | 1 | Output enable from a logic block's product term |
| core_i | output | 1 | Captured input value to the core |
| pad_i | input | 1 | Pad level |
| pad_o | output | 1 | Value for the pad driver |
| pad_oe | output | 1 | Enable for the pad driver |

## Verification
The hardest case to reach is the held state of the latched and registered modes while the core view diverges from the pad. The selected line must rise or sit high to load a value, then fall or stay high while `pad_i` keeps changing, and this must happen in every direction. In output direction the source is the cell's own driven value. The stimulus randomizes the pad, the core value, the enable and both I/O clock lines on every cycle, and it holds each configuration for tens of cycles, so these sequences occur many times. Meanwhile the configuration inputs are also randomized with the load strobe low, so any leak through an unloaded configuration shows up as a mismatch against the cycle model.

// File: rtl/pin_cell_pkg.sv
package pin_cell_pkg;

    typedef enum logic [1:0] {
        CAP_COMB     = 2'b00,
        CAP_REG      = 2'b01,
        CAP_LATCH    = 2'b10,
        CAP_COMB_ALT = 2'b11
    } cap_mode_e;

    typedef enum logic [1:0] {
        DIR_IN     = 2'b00,
        DIR_OUT    = 2'b01,
        DIR_BIDI   = 2'b10,
        DIR_IN_ALT = 2'b11
    } dir_mode_e;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_e;

endpackage

// File: rtl/pin_cell_cfg.sv
module pin_cell_cfg
    import pin_cell_pkg::*;
#(
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [1:0]       cap_in,
    input  logic [1:0]       dir_in,
    input  logic             inv_in,
    input  logic [SEL_W-1:0] sel_in,
    output cap_mode_e        cap_mode,
    output dir_mode_e        dir_mode,
    output logic             invert,
    output logic [SEL_W-1:0] sel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mode <= CAP_COMB;
            dir_mode <= DIR_IN;
            invert   <= 1'b0;
            sel      <= '0;
        end else if (load) begin
            cap_mode <= cap_mode_e'(cap_in);
            dir_mode <= dir_mode_e'(dir_in);
            invert   <= inv_in;
            sel      <= sel_in;
        end
    end

    // R2: without the strobe the stored configuration does not move
    a_r2_cfg_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(cap_mode) && $stable(dir_mode) && $stable(invert) && $stable(sel)));

endmodule

// File: rtl/pin_cell_line.sv
module pin_cell_line
    import pin_cell_pkg::*;
#(
    parameter int NCLK  = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCLK-1:0]  io_clk,
    input  logic [SEL_W-1:0] sel,
    output logic             line_lvl,
    output logic             line_rise
);

    line_state_e state_q, state_d;

    assign line_lvl = io_clk[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:  if (line_lvl)  state_d = LINE_HIGH;
            LINE_HIGH: if (!line_lvl) state_d = LINE_LOW;
        endcase
    end

    always_comb begin
        line_rise = 1'b0;
        unique case (state_q)
            LINE_LOW:  line_rise = line_lvl;
            LINE_HIGH: line_rise = 1'b0;
        endcase
    end

    // R4: a capture event is never followed directly by another
    a_r4_no_back_to_back_rise: assert property (@(posedge clk) disable iff (!rst_n)
        line_rise |=> !line_rise);

endmodule

// File: rtl/pin_cell_capture.sv
module pin_cell_capture
    import pin_cell_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cap_mode_e cap_mode,
    input  logic      line_lvl,
    input  logic      line_rise,
    input  logic      src,
    output logic      core_i
);

    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            unique case (cap_mode)
                CAP_REG:   if (line_rise) hold_q <= src;
                CAP_LATCH: if (line_lvl)  hold_q <= src;
                CAP_COMB, CAP_COMB_ALT: hold_q <= hold_q;
            endcase
        end
    end

    always_comb begin
        core_i = src;
        unique case (cap_mode)
            CAP_COMB, CAP_COMB_ALT: core_i = src;
            CAP_REG:                core_i = hold_q;
            CAP_LATCH:              core_i = line_lvl ? src : hold_q;
        endcase
    end

    // R4: in registered mode the stored bit moves only on a capture event
    a_r4_reg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == CAP_REG && !line_rise) |=> $stable(hold_q));

    // R5: with the line low the latch keeps its value
    a_r5_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == CAP_LATCH && !line_lvl) |=> $stable(hold_q));

    // R11: reset leaves the stored bit cleared
    a_r11_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (hold_q == 1'b0));

endmodule

// File: rtl/pin_cell_drive.sv
module pin_cell_drive
    import pin_cell_pkg::*;
(
    input  dir_mode_e dir_mode,
    input  logic      invert,
    input  logic      core_o,
    input  logic      core_oe,
    input  logic      pad_i,
    output logic      pad_o,
    output logic      pad_oe,
    output logic      src
);

    logic drv;

    always_comb begin
        drv    = core_o ^ invert;
        pad_oe = 1'b0;
        src    = pad_i;
        unique case (dir_mode)
            DIR_IN, DIR_IN_ALT: begin
                pad_oe = 1'b0;
                src    = pad_i;
            end
            DIR_OUT: begin
                pad_oe = 1'b1;
                src    = drv;
            end
            DIR_BIDI: begin
                pad_oe = core_oe;
                src    = pad_i;
            end
        endcase
    end

    assign pad_o = drv;

endmodule

// File: rtl/pin_cell.sv
module pin_cell
    import pin_cell_pkg::*;
#(
    parameter int NCLK  = 2,
    localparam int SEL_W = (NCLK > 1) ? $clog2(NCLK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCLK-1:0]  io_clk,
    input  logic             cfg_load,
    input  logic [1:0]       cfg_cap_mode,
    input  logic [1:0]       cfg_dir,
    input  logic             cfg_invert,
    input  logic [SEL_W-1:0] cfg_clk_sel,
    input  logic             core_o,
    input  logic             core_oe,
    output logic             core_i,
    input  logic             pad_i,
    output logic             pad_o,
    output logic             pad_oe
);

    cap_mode_e        cap_mode;
    dir_mode_e        dir_mode;
    logic             invert;
    logic [SEL_W-1:0] sel;
    logic             line_lvl;
    logic             line_rise;
    logic             src;

    pin_cell_cfg #(.SEL_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .cap_in   (cfg_cap_mode),
        .dir_in   (cfg_dir),
        .inv_in   (cfg_invert),
        .sel_in   (cfg_clk_sel),
        .cap_mode (cap_mode),
        .dir_mode (dir_mode),
        .invert   (invert),
        .sel      (sel)
    );

    pin_cell_line #(.NCLK(NCLK), .SEL_W(SEL_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_clk    (io_clk),
        .sel       (sel),
        .line_lvl  (line_lvl),
        .line_rise (line_rise)
    );

    pin_cell_drive u_drive (
        .dir_mode (dir_mode),
        .invert   (invert),
        .core_o   (core_o),
        .core_oe  (core_oe),
        .pad_i    (pad_i),
        .pad_o    (pad_o),
        .pad_oe   (pad_oe),
        .src      (src)
    );

    pin_cell_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_mode  (cap_mode),
        .line_lvl  (line_lvl),
        .line_rise (line_rise),
        .src       (src),
        .core_i    (core_i)
    );

    // R8: input direction never drives the pad
    a_r8_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode == DIR_IN || dir_mode == DIR_IN_ALT) |-> !pad_oe);

    // R9: output direction always drives, and the core reads the driven value
    a_r9_output_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode == DIR_OUT) |-> pad_oe);
    a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode == DIR_OUT && (cap_mode == CAP_COMB || cap_mode == CAP_COMB_ALT))
        |-> (core_i == pad_o));

    // R10: bidirectional enable comes from the logic block
    a_r10_bidi_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_mode == DIR_BIDI) |-> (pad_oe == core_oe));

    // R7: polarity selection
    a_r7_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        invert |-> (pad_o != core_o));

    // R5: latch transparent while the line is high (pad as source)
    a_r5_latch_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode == CAP_LATCH && dir_mode == DIR_BIDI && line_lvl) |-> (core_i == pad_i));

endmodule

// File: tb/sim_pin_cell.sv
module sim_pin_cell;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] io_clk;
    logic       cfg_load;
    logic [1:0] cfg_cap_mode;
    logic [1:0] cfg_dir;
    logic       cfg_invert;
    logic [0:0] cfg_clk_sel;
    logic       core_o, core_oe, pad_i;
    logic       core_i, pad_o, pad_oe;

    int checks = 0;
    int errs   = 0;

    // behavioural model state
    int m_mode, m_dir, m_inv, m_sel, m_prev, m_hold;

    always #10 clk = ~clk;

    pin_cell u0 (
        .clk(clk), .rst_n(rst_n), .io_clk(io_clk), .cfg_load(cfg_load),
        .cfg_cap_mode(cfg_cap_mode), .cfg_dir(cfg_dir), .cfg_invert(cfg_invert),
        .cfg_clk_sel(cfg_clk_sel), .core_o(core_o), .core_oe(core_oe),
        .core_i(core_i), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    task automatic model_reset();
        m_mode = 0; m_dir = 0; m_inv = 0; m_sel = 0; m_prev = 0; m_hold = 0;
    endtask

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s %s got=%0d expected=%0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    // one cycle: inputs are already set after a falling edge
    task automatic step(input string tag);
        int lvl, drv, src, exp_oe, exp_ci;
        #1;
        if (!rst_n) model_reset();
        lvl = int'(io_clk[m_sel]);
        drv = int'(core_o) ^ m_inv;
        src = (m_dir == 1) ? drv : int'(pad_i);
        exp_oe = (m_dir == 1) ? 1 : (m_dir == 2) ? int'(core_oe) : 0;
        if (m_mode == 1)      exp_ci = m_hold;
        else if (m_mode == 2) exp_ci = lvl ? src : m_hold;
        else                  exp_ci = src;
        check(tag, "pad_o", int'(pad_o), drv);
        check(tag, "pad_oe", int'(pad_oe), exp_oe);
        check(tag, "core_i", int'(core_i), exp_ci);
        @(posedge clk);
        if (rst_n) begin
            if (m_mode == 1 && lvl == 1 && m_prev == 0) m_hold = src;
            if (m_mode == 2 && lvl == 1) m_hold = src;
            m_prev = lvl;
            if (cfg_load) begin
                m_mode = int'(cfg_cap_mode); m_dir = int'(cfg_dir);
                m_inv = int'(cfg_invert);    m_sel = int'(cfg_clk_sel);
            end
        end else begin
            model_reset();
        end
        @(negedge clk);
    endtask

    task automatic load_cfg(input int mode, input int dir, input int inv, input int sel);
        cfg_cap_mode = 2'(mode); cfg_dir = 2'(dir);
        cfg_invert = 1'(inv); cfg_clk_sel = 1'(sel);
        cfg_load = 1'b1;
        step("R2");
        cfg_load = 1'b0;
    endtask

    // random pins and unloaded configuration noise (R2)
    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            pad_i = 1'($urandom); core_o = 1'($urandom); core_oe = 1'($urandom);
            io_clk = 2'($urandom);
            cfg_cap_mode = 2'($urandom); cfg_dir = 2'($urandom);
            cfg_invert = 1'($urandom); cfg_clk_sel = 1'($urandom);
            step(tag);
        end
    endtask

    initial begin
        #(20ns * 200000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        model_reset();
        rst_n = 1'b0; io_clk = 2'b00; cfg_load = 1'b0; cfg_cap_mode = 2'b01;
        cfg_dir = 2'b01; cfg_invert = 1'b1; cfg_clk_sel = 1'b1;
        core_o = 1'b1; core_oe = 1'b1; pad_i = 1'b1;
        @(negedge clk);
        step("R1");
        step("R1");
        rst_n = 1'b1;
        pad_i = 1'b0; step("R1");
        pad_i = 1'b1; step("R1");
        run(30, "R2");
        // combinatorial, both encodings, bidirectional
        load_cfg(0, 2, 0, 0); run(30, "R3");
        load_cfg(3, 2, 0, 0); run(30, "R3");
        // registered on line 0, then line 1
        load_cfg(1, 2, 0, 0); run(60, "R4");
        load_cfg(1, 0, 0, 1); run(60, "R6");
        // latched on both lines
        load_cfg(2, 2, 0, 0); run(60, "R5");
        load_cfg(2, 2, 1, 1); run(40, "R6");
        // polarity with output readback
        load_cfg(0, 1, 1, 0); run(30, "R7");
        load_cfg(0, 1, 0, 0); run(30, "R7");
        // directions
        load_cfg(0, 0, 0, 0); run(30, "R8");
        load_cfg(0, 3, 1, 0); run(30, "R8");
        load_cfg(1, 1, 1, 0); run(40, "R9");
        load_cfg(2, 1, 0, 1); run(40, "R9");
        load_cfg(0, 2, 1, 1); run(30, "R10");
        // asynchronous reset after a latch has captured a 1
        load_cfg(2, 2, 0, 0);
        pad_i = 1'b1; io_clk = 2'b01; step("R11");
        io_clk = 2'b00; pad_i = 1'b0; step("R11");
        rst_n = 1'b0; step("R11");
        rst_n = 1'b1; step("R11");
        run(20, "R11");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule